// File: doc/BRIEF.md
# Interrupt status and mask logic

This block keeps the eight status flags of a network controller's interrupt unit and the mask that picks which of them may interrupt the host. Some flags come from logic next to the block: remote-transfer done, and the stopped-controller flag. The others come from the transmit path (sent, send failed) and the receive path (frame accepted, frame in error, ring overrun). Each source signals an event with a one-cycle set pulse. The host reads back one status byte, which is the OR of all three flag groups.

The host acknowledges events by writing ones to the status byte. A set bit in the written byte clears the matching flag in whichever group holds it. The transmit and receive groups are also brought out on their own, so the paths that own those events can see that they were acknowledged. The interrupt line is a level. It is a register that follows the masked status one clock later. It drops again as soon as nothing enabled is pending, which happens when a flag is acknowledged or when the mask is narrowed.

The flag byte carries no data stream, so every pin is a plain control or status signal.

Top module: `intr_status_unit`

## Requirements
- R1: Out of reset the status byte reads 0x80 (only the stopped flag set), the mask reads 0x00 and `irq` is low.
- R2: A set pulse sets its flag, which is visible on `status_rd` in the cycle after the pulse. The flags are: receive OK on bit 0, transmit OK on bit 1, receive error on bit 2, transmit error on bit 3, overrun on bit 4, transfer done on bit 6, and stopped on bit 7 (`stop_set`). Bit 5 always reads 0.
- R3: `status_rd` is the OR of the local flags (bits 6 and 7), the transmit group and the receive group. `src_tx_o` only ever holds bits 1 and 3, and `src_rx_o` only ever holds bits 0, 2 and 4.
- R4: A write with `sts_wr` clears each of the bits 6:0 written as 1 and leaves the bits written as 0 alone. Bit 7 is never changed by a status write.
- R5: A status write that clears bit 1 or bit 3 clears that bit in `src_tx_o`. A write that clears bit 0, 2 or 4 clears that bit in `src_rx_o`.
- R6: `start_clr` clears bit 7 and `stop_set` sets it. When both are high in one cycle, the flag ends up set.
- R7: When a set pulse and a host clear hit the same bit in the same cycle, the bit ends up set.
- R8: A write with `msk_wr` loads `wr_data` into the mask, which is visible on `mask_rd` in the next cycle.
- R9: `irq` is a register equal to the OR of (status AND mask AND 0x7F) as it stood in the previous cycle. Bit 7 never raises `irq`.
- R10: `irq` falls one cycle after the masked status becomes zero. This happens when a flag is acknowledged or when the mask is narrowed, and no other action is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sts_wr | input | 1 | Host write strobe for the status byte (write ones to clear) |
| msk_wr | input | 1 | Host write strobe for the mask |
| wr_data | input | 8 | Host write data |
| rx_ok_set | input | 1 | Receive OK event pulse |
| rx_err_set | input | 1 | Receive error event pulse |
| rx_ovr_set | input | 1 | Receive overrun event pulse |
| tx_ok_set | input | 1 | Transmit OK event pulse |
| tx_err_set | input | 1 | Transmit error event pulse |
| dma_done_set | input | 1 | Remote transfer complete pulse |
| stop_set | input | 1 | Controller stopped: sets bit 7 |
| start_clr | input | 1 | Controller started: clears bit 7 |
| status_rd | output | 8 | Merged status byte |
| mask_rd | output | 8 | Mask readback |
| src_tx_o | output | 8 | Transmit-group flags |
| src_rx_o | output | 8 | Receive-group flags |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters. These start it with the stopped flag set and the mask cleared, so the unclearable bit 7 and its exclusion from the interrupt can be checked from the first cycle after reset. Directed steps cover the cases that matter most: a collision between a set and a clear, a start and a stop in the same cycle, and a fall of the line caused by the mask alone. A long random phase then mixes sparse writes and pulses, so that the line rises and falls many times against the reference model.

// File: rtl/intr_status_pkg.sv
package intr_status_pkg;
  localparam int STS_W = 8;

  // bit positions of the status byte
  localparam int B_RX_OK  = 0;
  localparam int B_TX_OK  = 1;
  localparam int B_RX_ERR = 2;
  localparam int B_TX_ERR = 3;
  localparam int B_RX_OVR = 4;
  localparam int B_DMA    = 6;
  localparam int B_RST    = 7;

  // flag groups
  localparam int NUM_BANKS = 3;
  localparam int BANK_TX   = 0;
  localparam int BANK_RX   = 1;
  localparam int BANK_LOC  = 2;

  localparam logic [STS_W-1:0] TX_OWN  = STS_W'((1 << B_TX_OK) | (1 << B_TX_ERR));
  localparam logic [STS_W-1:0] RX_OWN  = STS_W'((1 << B_RX_OK) | (1 << B_RX_ERR) | (1 << B_RX_OVR));
  localparam logic [STS_W-1:0] LOC_OWN = STS_W'((1 << B_DMA) | (1 << B_RST));

  localparam logic [NUM_BANKS-1:0][STS_W-1:0] BANK_OWN = {LOC_OWN, RX_OWN, TX_OWN};

  // bits the host may clear, and bits allowed to raise the line
  localparam logic [STS_W-1:0] HOST_CLEARABLE = ~STS_W'(1 << B_RST);
  localparam logic [STS_W-1:0] IRQ_ELIGIBLE   = ~STS_W'(1 << B_RST);
endpackage

// File: rtl/intr_flag_bank.sv
module intr_flag_bank #(
  parameter int               W    = 8,
  parameter logic [W-1:0]     OWN  = '0,
  parameter logic [W-1:0]     INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] host_clr_i,
  input  logic [W-1:0] side_clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  // clears first, then sets, so a set in the same cycle survives
  always_comb begin
    q_nxt = ((q_r & ~host_clr_i & ~side_clr_i) | set_i) & OWN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= INIT & OWN;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/intr_event_map.sv
module intr_event_map
  import intr_status_pkg::*;
(
  input  logic rx_ok_set,
  input  logic rx_err_set,
  input  logic rx_ovr_set,
  input  logic tx_ok_set,
  input  logic tx_err_set,
  input  logic dma_done_set,
  input  logic stop_set,
  input  logic start_clr,
  output logic [NUM_BANKS-1:0][STS_W-1:0] set_o,
  output logic [NUM_BANKS-1:0][STS_W-1:0] side_clr_o
);
  always_comb begin
    set_o      = '0;
    side_clr_o = '0;
    set_o[BANK_TX][B_TX_OK]  = tx_ok_set;
    set_o[BANK_TX][B_TX_ERR] = tx_err_set;
    set_o[BANK_RX][B_RX_OK]  = rx_ok_set;
    set_o[BANK_RX][B_RX_ERR] = rx_err_set;
    set_o[BANK_RX][B_RX_OVR] = rx_ovr_set;
    set_o[BANK_LOC][B_DMA]   = dma_done_set;
    set_o[BANK_LOC][B_RST]   = stop_set;
    side_clr_o[BANK_LOC][B_RST] = start_clr;
  end
endmodule

// File: rtl/intr_irq_gen.sv
module intr_irq_gen #(
  parameter int           W    = 8,
  parameter logic [W-1:0] ELIG = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic pending;
  logic irq_r;

  always_comb pending = |(status_i & mask_i & ELIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_r <= 1'b0;
    else        irq_r <= pending;
  end

  assign irq_o = irq_r;
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
  import intr_status_pkg::*;
#(
  parameter logic [STS_W-1:0] MASK_INIT     = '0,
  parameter logic             RST_FLAG_INIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sts_wr,
  input  logic             msk_wr,
  input  logic [STS_W-1:0] wr_data,
  input  logic             rx_ok_set,
  input  logic             rx_err_set,
  input  logic             rx_ovr_set,
  input  logic             tx_ok_set,
  input  logic             tx_err_set,
  input  logic             dma_done_set,
  input  logic             stop_set,
  input  logic             start_clr,
  output logic [STS_W-1:0] status_rd,
  output logic [STS_W-1:0] mask_rd,
  output logic [STS_W-1:0] src_tx_o,
  output logic [STS_W-1:0] src_rx_o,
  output logic             irq
);
  localparam logic [STS_W-1:0] LOC_INIT = STS_W'({RST_FLAG_INIT, 7'b0});

  logic [STS_W-1:0] host_clr;
  logic [STS_W-1:0] merged;
  logic [STS_W-1:0] mask_r;
  logic [NUM_BANKS-1:0][STS_W-1:0] bank_set;
  logic [NUM_BANKS-1:0][STS_W-1:0] bank_sclr;
  logic [NUM_BANKS-1:0][STS_W-1:0] bank_q;

  assign host_clr = sts_wr ? (wr_data & HOST_CLEARABLE) : '0;

  intr_event_map u_map (
    .rx_ok_set    (rx_ok_set),
    .rx_err_set   (rx_err_set),
    .rx_ovr_set   (rx_ovr_set),
    .tx_ok_set    (tx_ok_set),
    .tx_err_set   (tx_err_set),
    .dma_done_set (dma_done_set),
    .stop_set     (stop_set),
    .start_clr    (start_clr),
    .set_o        (bank_set),
    .side_clr_o   (bank_sclr)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [STS_W-1:0] INIT_B = (b == BANK_LOC) ? LOC_INIT : '0;
    intr_flag_bank #(
      .W    (STS_W),
      .OWN  (BANK_OWN[b]),
      .INIT (INIT_B)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (bank_set[b]),
      .host_clr_i (host_clr),
      .side_clr_i (bank_sclr[b]),
      .q_o        (bank_q[b])
    );
  end

  always_comb begin
    merged = '0;
    for (int b = 0; b < NUM_BANKS; b++) merged |= bank_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_r <= MASK_INIT;
    else if (msk_wr) mask_r <= wr_data;
  end

  intr_irq_gen #(
    .W    (STS_W),
    .ELIG (IRQ_ELIGIBLE)
  ) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (merged),
    .mask_i   (mask_r),
    .irq_o    (irq)
  );

  assign status_rd = merged;
  assign mask_rd   = mask_r;
  assign src_tx_o  = bank_q[BANK_TX];
  assign src_rx_o  = bank_q[BANK_RX];
endmodule

// File: rtl/intr_status_checker.sv
module intr_status_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sts_wr,
  input logic       msk_wr,
  input logic [7:0] wr_data,
  input logic       tx_ok_set,
  input logic       dma_done_set,
  input logic       stop_set,
  input logic       start_clr,
  input logic [7:0] status_rd,
  input logic [7:0] mask_rd,
  input logic [7:0] src_tx_o,
  input logic       irq
);
  a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_rd & mask_rd & 8'h7F)) |=> irq);

  a_r10_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_rd & mask_rd & 8'h7F)) |=> !irq);

  a_r4_bit7_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd[7] && sts_wr && !start_clr) |=> status_rd[7]);

  a_r5_tx_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wr_data[1] && !tx_ok_set) |=> !src_tx_o[1]);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wr_data[6] && dma_done_set) |=> status_rd[6]);

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_clr && !stop_set) |=> !status_rd[7]);

  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    msk_wr |=> (mask_rd == $past(wr_data)));
endmodule

bind intr_status_unit intr_status_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sts_wr       (sts_wr),
  .msk_wr       (msk_wr),
  .wr_data      (wr_data),
  .tx_ok_set    (tx_ok_set),
  .dma_done_set (dma_done_set),
  .stop_set     (stop_set),
  .start_clr    (start_clr),
  .status_rd    (status_rd),
  .mask_rd      (mask_rd),
  .src_tx_o     (src_tx_o),
  .irq          (irq)
);

// File: tb/intr_status_unit_bench.sv
`timescale 1ns/1ps
module intr_status_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sts_wr = 0, msk_wr = 0;
  logic [7:0] wr_data = 0;
  logic       rx_ok_set = 0, rx_err_set = 0, rx_ovr_set = 0;
  logic       tx_ok_set = 0, tx_err_set = 0, dma_done_set = 0;
  logic       stop_set = 0, start_clr = 0;
  logic [7:0] status_rd, mask_rd, src_tx_o, src_rx_o;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intr_status_unit u_intr_status_unit (
    .clk(clk), .rst_n(rst_n), .sts_wr(sts_wr), .msk_wr(msk_wr), .wr_data(wr_data),
    .rx_ok_set(rx_ok_set), .rx_err_set(rx_err_set), .rx_ovr_set(rx_ovr_set),
    .tx_ok_set(tx_ok_set), .tx_err_set(tx_err_set), .dma_done_set(dma_done_set),
    .stop_set(stop_set), .start_clr(start_clr), .status_rd(status_rd),
    .mask_rd(mask_rd), .src_tx_o(src_tx_o), .src_rx_o(src_rx_o), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each rising edge
  logic [7:0] m_sts, m_mask;
  logic       m_irq;
  always @(posedge clk) begin
    logic [7:0] nxt;
    if (!rst_n) begin
      m_sts = 8'h80; m_mask = 8'h00; m_irq = 1'b0;
    end else begin
      m_irq = ((m_sts & m_mask & 8'h7F) != 0);
      nxt = m_sts;
      if (sts_wr) nxt = nxt & ~(wr_data & 8'h7F);
      if (start_clr) nxt[7] = 1'b0;
      if (rx_ok_set)    nxt[0] = 1'b1;
      if (tx_ok_set)    nxt[1] = 1'b1;
      if (rx_err_set)   nxt[2] = 1'b1;
      if (tx_err_set)   nxt[3] = 1'b1;
      if (rx_ovr_set)   nxt[4] = 1'b1;
      if (dma_done_set) nxt[6] = 1'b1;
      if (stop_set)     nxt[7] = 1'b1;
      m_sts = nxt;
      if (msk_wr) m_mask = wr_data;
    end
  end

  // compare with the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 status", status_rd, m_sts);
      chk("R8 mask", mask_rd, m_mask);
      chk("R9 irq", {7'b0, irq}, {7'b0, m_irq});
      chk("R5 tx group", src_tx_o, m_sts & 8'h0A);
      chk("R5 rx group", src_rx_o, m_sts & 8'h15);
    end
  end

  task automatic idle();
    sts_wr = 0; msk_wr = 0; wr_data = 0;
    rx_ok_set = 0; rx_err_set = 0; rx_ovr_set = 0;
    tx_ok_set = 0; tx_err_set = 0; dma_done_set = 0;
    stop_set = 0; start_clr = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    // R1: reset state
    chk("R1 status", status_rd, 8'h80);
    chk("R1 mask", mask_rd, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2: each event sets its own bit
    rx_ok_set = 1;    cyc(); idle(); chk("R2 rx ok", status_rd, 8'h81);
    tx_ok_set = 1;    cyc(); idle(); chk("R2 tx ok", status_rd, 8'h83);
    rx_err_set = 1;   cyc(); idle(); chk("R2 rx err", status_rd, 8'h87);
    tx_err_set = 1;   cyc(); idle(); chk("R2 tx err", status_rd, 8'h8F);
    rx_ovr_set = 1;   cyc(); idle(); chk("R2 overrun", status_rd, 8'h9F);
    dma_done_set = 1; cyc(); idle(); chk("R2 dma done", status_rd, 8'hDF);
    // R3: groups hold only their own bits
    chk("R3 tx group", src_tx_o, 8'h0A);
    chk("R3 rx group", src_rx_o, 8'h15);

    // R4: write-one-clear, bit 7 untouched
    sts_wr = 1; wr_data = 8'h02; cyc(); idle();
    chk("R4 clear bit1", status_rd, 8'hDD);
    chk("R5 tx ack", src_tx_o, 8'h08);
    sts_wr = 1; wr_data = 8'h80; cyc(); idle();
    chk("R4 bit7 kept", status_rd, 8'hDD);

    // R5: receive acknowledgements reach the receive group
    sts_wr = 1; wr_data = 8'h15; cyc(); idle();
    chk("R5 rx ack", src_rx_o, 8'h00);
    chk("R5 status", status_rd, 8'hC8);

    // R7: set beats clear on the same bit
    sts_wr = 1; wr_data = 8'h40; dma_done_set = 1; cyc(); idle();
    chk("R7 set wins", status_rd, 8'hC8);

    // R6: start clears, stop+start sets
    start_clr = 1; cyc(); idle(); chk("R6 start", status_rd, 8'h48);
    start_clr = 1; stop_set = 1; cyc(); idle(); chk("R6 both", status_rd, 8'hC8);
    sts_wr = 1; wr_data = 8'h48; cyc(); idle(); chk("R4 clear", status_rd, 8'h80);

    // R9: bit 7 alone never raises the line
    msk_wr = 1; wr_data = 8'h80; cyc(); idle();
    chk("R8 mask", mask_rd, 8'h80);
    cyc(); cyc(); chk("R9 bit7 masked out", {7'b0, irq}, 8'h00);

    // R9: registered rise, one cycle after the enabling write
    tx_err_set = 1; cyc(); idle();
    msk_wr = 1; wr_data = 8'h08; cyc(); idle();
    chk("R8 mask", mask_rd, 8'h08);
    chk("R9 irq not yet", {7'b0, irq}, 8'h00);
    cyc(); chk("R9 irq up", {7'b0, irq}, 8'h01);

    // R10: drop after acknowledge
    sts_wr = 1; wr_data = 8'h08; cyc(); idle();
    chk("R10 irq held", {7'b0, irq}, 8'h01);
    cyc(); chk("R10 irq down ack", {7'b0, irq}, 8'h00);

    // R10: drop after mask narrowing
    tx_err_set = 1; cyc(); idle(); cyc();
    chk("R9 irq up again", {7'b0, irq}, 8'h01);
    msk_wr = 1; wr_data = 8'h00; cyc(); idle();
    cyc(); chk("R10 irq down mask", {7'b0, irq}, 8'h00);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      idle();
      sts_wr       = ($urandom_range(0, 9) == 0);
      msk_wr       = ($urandom_range(0, 19) == 0);
      wr_data      = 8'($urandom_range(0, 255));
      rx_ok_set    = ($urandom_range(0, 11) == 0);
      rx_err_set   = ($urandom_range(0, 15) == 0);
      rx_ovr_set   = ($urandom_range(0, 23) == 0);
      tx_ok_set    = ($urandom_range(0, 11) == 0);
      tx_err_set   = ($urandom_range(0, 15) == 0);
      dma_done_set = ($urandom_range(0, 13) == 0);
      stop_set     = ($urandom_range(0, 29) == 0);
      start_clr    = ($urandom_range(0, 29) == 0);
      cyc();
    end
    idle();
    cyc(); cyc();
    done = 1;
    summary();
    $finish;
  end
endmodule